// File: doc/BRIEF.md
# Bounded Dictionary Value Decompressor

This block rebuilds 64-bit double-precision matrix values from a compressed token stream for a streaming sparse matrix-vector pipeline. The most frequent values are kept in an on-chip table of bounded size. A compressed token names one of them by a short index, and any other value travels in the token as a full literal. Two decode lanes read the same table, each through its own read port, so one table serves two processing pipelines.

Software first fills the table through a write port and then asserts a load-done strobe. After that strobe the table is locked and read-only, and both lanes start to accept tokens. Each lane takes one token per cycle with a valid/ready handshake and returns the decoded value one cycle later, also with valid/ready. Back-pressure on the output stalls the lane without losing or repeating a token. The number of usable table entries is a live configuration input. When it is zero, only literal tokens decode correctly, which gives plain uncompressed operation.

Top module: `dict_decomp`

## Requirements
- R1: After reset, every `out_valid` bit, every `in_ready` bit and `err_flag` are 0.
- R2: Until `ld_done` has been sampled high at a clock edge, `in_ready` stays 0 and no token is accepted, whatever `in_valid` does.
- R3: An accepted token whose tag bit is 0 carries a table index in payload bits [IDX_W-1:0], IDX_W being 12 by default. When that index is below `cfg_count`, the lane outputs the stored 64-bit entry at that index in the cycle after acceptance. Index 4095 with `cfg_count` = 4096 is a valid case.
- R4: An accepted token whose tag bit is 1 is a literal, and its 64-bit payload is output unchanged with the same one-cycle latency.
- R5: Within each lane, outputs come out in the same order as the tokens were accepted, for any mix of index and literal tokens.
- R6: While `out_ready` is held high and tokens are offered without gaps, a lane accepts one token on every cycle with no wait.
- R7: While a lane shows `out_valid` = 1 and `out_ready` = 0, its `in_ready` is 0 in that same cycle, and `out_valid` and `out_data` hold their values into the next cycle.
- R8: An index token whose index is at or above `cfg_count` is output as zero and sets `err_flag`, which then stays set until reset. An index equal to `cfg_count` - 1 is still decoded normally.
- R9: With `cfg_count` = 0, every index token is output as zero and flagged, while literal tokens still pass unchanged.
- R10: Table writes presented after `ld_done` has been sampled are ignored, so a later decode of that entry returns the value loaded before the lock.
- R11: The two lanes decode independently and may read the same table entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Table write enable (honoured only before lock) |
| ld_addr | input | IDX_W | Table write address |
| ld_data | input | 64 | Table write data |
| ld_done | input | 1 | Load finished; locks the table and enables decoding |
| cfg_count | input | IDX_W+1 | Number of valid table entries (0 to 2^IDX_W) |
| in_valid | input | 2 | Per-lane token valid |
| in_tag | input | 2 | Per-lane token tag: 0 index, 1 literal |
| in_data | input | 2x64 | Per-lane token payload |
| in_ready | output | 2 | Per-lane token ready |
| out_valid | output | 2 | Per-lane decoded value valid |
| out_data | output | 2x64 | Per-lane decoded value |
| out_ready | input | 2 | Per-lane downstream ready |
| err_flag | output | 1 | Sticky out-of-range index flag |

## Verification
Some properties are checked on every clock by assertions. These are: no acceptance before the lock, an output one cycle after each accept, the hold-and-drop-ready rule under back-pressure, zero output on flagged slots, and the stickiness of the error flag. The same assertions check that no table write gets through after the lock. A scoreboard has to show that the values themselves are correct. It checks the table contents seen through the lanes, the literal pass-through, the ordering under random stalls, the boundary indices at `cfg_count` - 1, `cfg_count` and 4095, the zero-entry configuration, and that a write after the lock does not take effect.

// File: rtl/dvd_pkg.sv
package dvd_pkg;

  // Token tag encoding shared by the lanes and the bench.
  typedef enum logic {
    TAG_INDEX   = 1'b0,
    TAG_LITERAL = 1'b1
  } tok_tag_e;

  // Number of read ports on the shared table (one per lane).
  localparam int unsigned LANES = 2;

endpackage

// File: rtl/dvd_table.sv
module dvd_table #(
  parameter int unsigned IDX_W = 12,
  parameter int unsigned VAL_W = 64,
  parameter int unsigned NPORT = 2
) (
  input  logic                        clk,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_addr,
  input  logic [VAL_W-1:0]            wr_data,
  input  logic [NPORT-1:0]            rd_en,
  input  logic [NPORT-1:0][IDX_W-1:0] rd_addr,
  output logic [NPORT-1:0][VAL_W-1:0] rd_data
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [VAL_W-1:0] mem [DEPTH];

  // Single write port, used only while the table is being filled.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // One registered read port per lane; the register holds while not enabled.
  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    logic [VAL_W-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (rd_en[p]) begin
        rd_q <= mem[rd_addr[p]];
      end
    end
    assign rd_data[p] = rd_q;
  end

endmodule

// File: rtl/dvd_load_ctl.sv
module dvd_load_ctl #(
  parameter int unsigned IDX_W = 12,
  parameter int unsigned VAL_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_we,
  input  logic [IDX_W-1:0] ld_addr,
  input  logic [VAL_W-1:0] ld_data,
  input  logic             ld_done,
  output logic             tbl_we,
  output logic [IDX_W-1:0] tbl_addr,
  output logic [VAL_W-1:0] tbl_data,
  output logic             dec_en
);

  logic locked_q;

  // The lock is sticky: once loading is declared done the table is read-only.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
    end else if (ld_done) begin
      locked_q <= 1'b1;
    end
  end

  assign tbl_we   = ld_we & ~locked_q;
  assign tbl_addr = ld_addr;
  assign tbl_data = ld_data;
  assign dec_en   = locked_q;

endmodule

// File: rtl/dvd_lane.sv
module dvd_lane
  import dvd_pkg::*;
#(
  parameter int unsigned IDX_W = 12,
  parameter int unsigned VAL_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_en,
  input  logic [IDX_W:0]   cfg_count,
  input  logic             in_valid,
  input  logic             in_tag,
  input  logic [VAL_W-1:0] in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [VAL_W-1:0] out_data,
  input  logic             out_ready,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_addr,
  input  logic [VAL_W-1:0] rd_data,
  output logic             accept_evt,
  output logic             fire_evt,
  output logic             bad_evt,
  output logic             slot_err
);

  // True when the index names a loaded entry.
  function automatic logic f_index_ok(input logic [IDX_W-1:0] idx,
                                      input logic [IDX_W:0]   count);
    return {1'b0, idx} < count;
  endfunction

  // Output selection for the registered slot.
  function automatic logic [VAL_W-1:0] f_pick(input logic             tag,
                                               input logic             err,
                                               input logic [VAL_W-1:0] lit,
                                               input logic [VAL_W-1:0] ram);
    if (tag == TAG_LITERAL) return lit;
    if (err)                return '0;
    return ram;
  endfunction

  logic             slot_v_q;
  logic             slot_tag_q;
  logic             slot_err_q;
  logic [VAL_W-1:0] slot_lit_q;
  logic             advance;
  logic [IDX_W-1:0] tok_idx;
  logic             tok_is_index;
  logic             tok_ok;

  assign tok_idx      = in_data[IDX_W-1:0];
  assign tok_is_index = (in_tag == TAG_INDEX);
  assign tok_ok       = f_index_ok(tok_idx, cfg_count);

  // The slot moves when it is empty or its value is being taken.
  assign advance    = ~slot_v_q | out_ready;
  assign in_ready   = dec_en & advance;
  assign accept_evt = in_valid & in_ready;
  assign bad_evt    = accept_evt & tok_is_index & ~tok_ok;

  // Only in-range index tokens read the table; the read register
  // then holds its value for as long as the slot is stalled.
  assign rd_en   = accept_evt & tok_is_index & tok_ok;
  assign rd_addr = tok_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_v_q   <= 1'b0;
      slot_tag_q <= 1'b0;
      slot_err_q <= 1'b0;
    end else if (advance) begin
      slot_v_q   <= accept_evt;
      slot_tag_q <= in_tag;
      slot_err_q <= bad_evt;
    end
  end

  // Literal path register matching the table read latency.
  always_ff @(posedge clk) begin
    if (accept_evt) begin
      slot_lit_q <= in_data;
    end
  end

  assign out_valid = slot_v_q;
  assign out_data  = f_pick(slot_tag_q, slot_err_q, slot_lit_q, rd_data);
  assign fire_evt  = slot_v_q & out_ready;
  assign slot_err  = slot_v_q & slot_err_q & (slot_tag_q == TAG_INDEX);

endmodule

// File: rtl/dict_decomp.sv
module dict_decomp
  import dvd_pkg::*;
#(
  parameter int unsigned IDX_W = 12,
  parameter int unsigned VAL_W = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ld_we,
  input  logic [IDX_W-1:0]            ld_addr,
  input  logic [VAL_W-1:0]            ld_data,
  input  logic                        ld_done,
  input  logic [IDX_W:0]              cfg_count,
  input  logic [LANES-1:0]            in_valid,
  input  logic [LANES-1:0]            in_tag,
  input  logic [LANES-1:0][VAL_W-1:0] in_data,
  output logic [LANES-1:0]            in_ready,
  output logic [LANES-1:0]            out_valid,
  output logic [LANES-1:0][VAL_W-1:0] out_data,
  input  logic [LANES-1:0]            out_ready,
  output logic                        err_flag
);

  logic                        tbl_we;
  logic [IDX_W-1:0]            tbl_addr;
  logic [VAL_W-1:0]            tbl_data;
  logic                        dec_en;
  logic [LANES-1:0]            rd_en;
  logic [LANES-1:0][IDX_W-1:0] rd_addr;
  logic [LANES-1:0][VAL_W-1:0] rd_data;

  // Named per-lane events, brought out for the checker.
  logic [LANES-1:0] lane_accept;
  logic [LANES-1:0] lane_fire;
  logic [LANES-1:0] lane_bad;
  logic [LANES-1:0] lane_slot_err;
  logic             err_q;

  dvd_load_ctl #(.IDX_W(IDX_W), .VAL_W(VAL_W)) u_ld (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_we    (ld_we),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data),
    .ld_done  (ld_done),
    .tbl_we   (tbl_we),
    .tbl_addr (tbl_addr),
    .tbl_data (tbl_data),
    .dec_en   (dec_en)
  );

  dvd_table #(.IDX_W(IDX_W), .VAL_W(VAL_W), .NPORT(LANES)) u_tbl (
    .clk     (clk),
    .wr_en   (tbl_we),
    .wr_addr (tbl_addr),
    .wr_data (tbl_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dvd_lane #(.IDX_W(IDX_W), .VAL_W(VAL_W)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .dec_en     (dec_en),
      .cfg_count  (cfg_count),
      .in_valid   (in_valid[l]),
      .in_tag     (in_tag[l]),
      .in_data    (in_data[l]),
      .in_ready   (in_ready[l]),
      .out_valid  (out_valid[l]),
      .out_data   (out_data[l]),
      .out_ready  (out_ready[l]),
      .rd_en      (rd_en[l]),
      .rd_addr    (rd_addr[l]),
      .rd_data    (rd_data[l]),
      .accept_evt (lane_accept[l]),
      .fire_evt   (lane_fire[l]),
      .bad_evt    (lane_bad[l]),
      .slot_err   (lane_slot_err[l])
    );
  end

  // Sticky error: any lane presenting an out-of-range index sets it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (|lane_bad) begin
      err_q <= 1'b1;
    end
  end

  assign err_flag = err_q;

endmodule

// File: rtl/dvd_checker.sv
module dvd_checker
  import dvd_pkg::*;
#(
  parameter int unsigned IDX_W = 12,
  parameter int unsigned VAL_W = 64
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        ld_done,
  input logic [LANES-1:0]            in_valid,
  input logic [LANES-1:0]            in_ready,
  input logic [LANES-1:0]            out_valid,
  input logic [LANES-1:0][VAL_W-1:0] out_data,
  input logic [LANES-1:0]            out_ready,
  input logic                        err_flag,
  input logic                        tbl_we,
  input logic [LANES-1:0]            lane_bad,
  input logic [LANES-1:0]            lane_slot_err
);

  // Independent record of whether loading has been declared done.
  logic seen_done_q;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_done_q <= 1'b0;
    else if (ld_done) seen_done_q <= 1'b1;
  end

  AST_NO_EARLY_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_done_q |-> (in_ready == '0)); // R2

  AST_TABLE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    seen_done_q |-> !tbl_we); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R8

  AST_BAD_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_bad) |=> err_flag); // R8

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    AST_ONE_CYCLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[l] && in_ready[l]) |=> out_valid[l]); // R3

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[l] && !out_ready[l]) |=> (out_valid[l] && $stable(out_data[l]))); // R7

    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[l] && !out_ready[l]) |-> !in_ready[l]); // R7

    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      lane_slot_err[l] |-> (out_data[l] == '0)); // R8
  end

endmodule

bind dict_decomp dvd_checker #(.IDX_W(IDX_W), .VAL_W(VAL_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ld_done       (ld_done),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_data      (out_data),
  .out_ready     (out_ready),
  .err_flag      (err_flag),
  .tbl_we        (tbl_we),
  .lane_bad      (lane_bad),
  .lane_slot_err (lane_slot_err)
);

// File: tb/dict_decomp_tb.sv
module dict_decomp_tb;

  localparam int unsigned IDX_W = 12;
  localparam int unsigned VAL_W = 64;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ld_we = 1'b0;
  logic [IDX_W-1:0] ld_addr = '0;
  logic [VAL_W-1:0] ld_data = '0;
  logic             ld_done = 1'b0;
  logic [IDX_W:0]   cfg_count = '0;
  logic [1:0]            in_valid, in_tag, in_ready, out_valid, out_ready;
  logic [1:0][VAL_W-1:0] in_data, out_data;
  logic             err_flag;

  // Per-lane bench variables, one writer each.
  logic v0 = 0, v1 = 0, t0 = 0, t1 = 0, r0 = 1, r1 = 1;
  logic [VAL_W-1:0] d0 = '0, d1 = '0;
  assign in_valid  = {v1, v0};
  assign in_tag    = {t1, t0};
  assign in_data   = {d1, d0};
  assign out_ready = {r1, r0};

  always #2.5 clk = ~clk; // 200 MHz

  dict_decomp #(.IDX_W(IDX_W), .VAL_W(VAL_W)) u_dut (
    .clk, .rst_n, .ld_we, .ld_addr, .ld_data, .ld_done, .cfg_count,
    .in_valid, .in_tag, .in_data, .in_ready, .out_valid, .out_data,
    .out_ready, .err_flag
  );

  int n_checks = 0;
  int n_fail   = 0;
  int waits0 = 0, waits1 = 0;
  logic stall_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [VAL_W-1:0] model [DEPTH];
  logic [VAL_W-1:0] expq0[$], expq1[$];
  string            reqq0[$], reqq1[$];

  function automatic logic [VAL_W-1:0] entry_val(input int i);
    return {32'h3FF0_0000 + i[31:0], 32'h5A5A_0000 ^ (i[31:0] * 32'd977)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [VAL_W-1:0] act,
                       input logic [VAL_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: called just after a rising edge; returns just after the edge
  // that took the token, so consecutive calls give a gap-free stream.
  task automatic send(input int ln, input logic tg, input logic [VAL_W-1:0] d,
                      input string req);
    logic [VAL_W-1:0] exp;
    if (tg) exp = d;
    else if ({1'b0, d[IDX_W-1:0]} < cfg_count) exp = model[d[IDX_W-1:0]];
    else exp = '0;
    if (ln == 0) begin v0 = 1; t0 = tg; d0 = d; end
    else         begin v1 = 1; t1 = tg; d1 = d; end
    forever begin
      @(negedge clk);
      if (in_ready[ln]) break;
      if (ln == 0) waits0++; else waits1++;
    end
    if (ln == 0) begin expq0.push_back(exp); reqq0.push_back(req); end
    else         begin expq1.push_back(exp); reqq1.push_back(req); end
    @(posedge clk); #1;
    if (ln == 0) v0 = 0; else v1 = 0;
  endtask

  function automatic logic [VAL_W-1:0] idx_tok(input int i);
    return {{(VAL_W-IDX_W){1'b0}}, i[IDX_W-1:0]};
  endfunction

  // Output ready pattern.
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    r0 = stall_mode ? lfsr[3] : 1'b1;
    r1 = stall_mode ? lfsr[9] : 1'b1;
  end

  // Monitor: pops and compares each transfer; also checks stall holding.
  logic             held0 = 0, held1 = 0;
  logic [VAL_W-1:0] hd0, hd1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held0) check(out_valid[0] && out_data[0] == hd0, "R7 lane0 hold", out_data[0], hd0);
      if (held1) check(out_valid[1] && out_data[1] == hd1, "R7 lane1 hold", out_data[1], hd1);
      held0 = out_valid[0] && !out_ready[0]; hd0 = out_data[0];
      held1 = out_valid[1] && !out_ready[1]; hd1 = out_data[1];
      if (held0) check(!in_ready[0], "R7 lane0 ready drop", {63'b0, in_ready[0]}, '0);
      if (held1) check(!in_ready[1], "R7 lane1 ready drop", {63'b0, in_ready[1]}, '0);
      if (out_valid[0] && out_ready[0]) begin
        if (expq0.size() == 0) check(0, "R5 lane0 unexpected output", out_data[0], '0);
        else begin
          logic [VAL_W-1:0] e; string rq;
          e = expq0.pop_front(); rq = reqq0.pop_front();
          check(out_data[0] == e, rq, out_data[0], e);
        end
      end
      if (out_valid[1] && out_ready[1]) begin
        if (expq1.size() == 0) check(0, "R5 lane1 unexpected output", out_data[1], '0);
        else begin
          logic [VAL_W-1:0] e; string rq;
          e = expq1.pop_front(); rq = reqq1.pop_front();
          check(out_data[1] == e, rq, out_data[1], e);
        end
      end
    end
  end

  task automatic drain();
    for (int k = 0; k < 200 && (expq0.size() != 0 || expq1.size() != 0); k++) @(posedge clk);
    @(posedge clk); #1;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(out_valid == 2'b00, "R1 out_valid", {62'b0, out_valid}, '0);
    check(in_ready == 2'b00, "R1 in_ready", {62'b0, in_ready}, '0);
    check(!err_flag, "R1 err_flag", {63'b0, err_flag}, '0);

    // R2: offer tokens before loading is done
    @(posedge clk); #1;
    v0 = 1; t0 = 1; d0 = 64'h1234; v1 = 1; t1 = 0; d1 = '0; cfg_count = 16;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(in_ready == 2'b00, "R2 in_ready before load", {62'b0, in_ready}, '0);
      check(out_valid == 2'b00, "R2 no output before load", {62'b0, out_valid}, '0);
    end
    @(posedge clk); #1; v0 = 0; v1 = 0;

    // Load entries 0..15 and the top entry
    for (int i = 0; i < 17; i++) begin
      int a;
      a = (i == 16) ? DEPTH - 1 : i;
      ld_we = 1; ld_addr = a[IDX_W-1:0]; ld_data = entry_val(a); model[a] = entry_val(a);
      @(posedge clk); #1;
    end
    ld_we = 0; ld_done = 1;
    @(posedge clk); #1;
    ld_done = 0;
    // R10: write after lock must be ignored (model unchanged)
    ld_we = 1; ld_addr = 3; ld_data = 64'hDEAD_BEEF_DEAD_BEEF;
    @(posedge clk); #1;
    ld_we = 0;

    // R3 R4 R5 R6 R11 R10: back-to-back mixed streams on both lanes
    waits0 = 0; waits1 = 0;
    fork
      for (int i = 0; i < 24; i++) begin
        if (i % 3 == 2) send(0, 1, 64'hC000_0000_0000_0000 + i, "R4 lane0 literal");
        else send(0, 0, idx_tok(i % 16), (i % 16 == 3) ? "R10 lane0 locked entry" : "R3 lane0 index");
      end
      for (int i = 0; i < 24; i++) begin
        if (i % 4 == 1) send(1, 1, 64'h7FF8_0000_0000_0000 ^ i, "R5 lane1 literal order");
        else send(1, 0, idx_tok(i % 16), "R11 lane1 shared index");
      end
    join
    check(waits0 == 0, "R6 lane0 no wait", waits0, 0);
    check(waits1 == 0, "R6 lane1 no wait", waits1, 0);
    drain();

    // R7 R5: random back-pressure
    stall_mode = 1;
    fork
      for (int i = 0; i < 40; i++) send(0, i[0], (i[0] ? 64'hABCD_0000 + i : idx_tok(15 - (i % 16))), "R5 lane0 stalled order");
      for (int i = 0; i < 40; i++) send(1, i[1], (i[1] ? 64'h1357_0000 + i : idx_tok(i % 16)), "R5 lane1 stalled order");
    join
    drain();
    stall_mode = 0;
    @(posedge clk); #1;

    // R8: boundary indices
    send(0, 0, idx_tok(15), "R8 index count-1 valid");
    drain();
    @(negedge clk);
    check(!err_flag, "R8 no error for count-1", {63'b0, err_flag}, '0);
    @(posedge clk); #1;
    send(0, 0, idx_tok(16), "R8 index at count gives zero");
    send(1, 0, idx_tok(200), "R8 index above count gives zero");
    @(negedge clk);
    check(err_flag, "R8 error raised", {63'b0, err_flag}, 64'd1);
    drain();
    send(0, 1, 64'h4242, "R8 literal after error");
    drain();
    @(negedge clk);
    check(err_flag, "R8 error sticky", {63'b0, err_flag}, 64'd1);
    @(posedge clk); #1;

    // R3: top index with full table configured
    cfg_count = DEPTH[IDX_W:0];
    send(1, 0, idx_tok(DEPTH - 1), "R3 top index 4095");
    drain();

    // R9: no dictionary entries at all
    cfg_count = 0;
    send(0, 0, idx_tok(0), "R9 index with empty table");
    send(0, 1, 64'h3FF0_0000_0000_0001, "R9 literal with empty table");
    send(1, 0, idx_tok(5), "R9 lane1 index with empty table");
    drain();

    check(expq0.size() == 0 && expq1.size() == 0, "R5 all outputs delivered",
          expq0.size() + expq1.size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule